// File: doc/BRIEF.md
# Transactional Memory Commit Tracker

This block sits next to the in-order retirement stage of a multithreaded out-of-order core. It follows the hardware transactional memory state of every hardware thread. Each cycle it accepts up to `RET_W` retiring-instruction slots. Each slot carries a thread ID, a transaction-begin flag, a transaction-end flag, the instruction's own in-transaction flag, a transaction ID and a fault code with its cause.

For every thread the block keeps a begin counter and an end counter. A thread is inside a transaction while its begin count exceeds its end count. That state drives four decisions:
- An interrupt aimed at a thread inside a transaction is squashed instead of taken, and a livelock-avoidance hold is raised.
- A fault raised inside a transaction is rewritten into a transaction-failure fault.
- A drain request is refused while any thread is inside a transaction.
- The transaction ID of each retiring begin instruction is kept per thread, for debug and correctness checks.

A per-thread clear command resets that thread's counters. Counters saturate at their maximum value and raise an overflow flag.

Top module: `txn_commit_tracker`

## Requirements
- R1: After reset every counter and every last-ID register is zero, no thread is inside a transaction, and `intTake`, `intSquash`, `livelockHold`, `drainGrant`, `drainErr`, `checkErr` and `ovfErr` are low.
- R2: `inTxMask[t]` is high exactly when thread t's begin count is greater than its end count. `qryInTx` reports this for `qryTid`. The all-ones thread ID (7 with defaults) is invalid: it always reads as not inside a transaction. A slot carrying an invalid ID changes no counter and is not consistency-checked.
- R3: For a retiring begin instruction, the begin counter is incremented before the consistency check. For a retiring end instruction, the end counter is incremented after it. The new counts are visible one cycle after the retiring edge.
- R4: When a slot's in-transaction flag differs from the thread's state computed as in R3, `checkErr` goes high one cycle later and stays high until reset.
- R5: When `intPending` is high and thread `intTid` is inside a transaction, `intSquash` pulses one cycle later, `intTake` stays low and `livelockHold` is set.
- R6: When `intPending` is high and thread `intTid` is not inside a transaction, `intTake` pulses one cycle later and `livelockHold` is cleared.
- R7: A valid slot with its in-transaction flag set and a fault code other than 0 (no fault) and other than 4'hE (transaction failure) produces, one cycle later, code 4'hE, cause 3'd1 (exception) and the slot's own transaction ID.
- R8: A fault code 4'hE, or any fault on a slot whose in-transaction flag is clear, appears one cycle later with its code, cause and transaction ID unchanged.
- R9: A retiring begin instruction writes its transaction ID into its thread's last-ID register. If two slots of the same thread both begin, the higher-numbered slot's ID is kept. `qryLastId` shows the register for `qryTid`.
- R10: On `drainReq`, if any thread is inside a transaction, `drainErr` is set one cycle later and stays set, and `drainGrant` stays low. Otherwise `drainGrant` pulses one cycle later.
- R11: A clear command (`clrValid`, `clrTid`) sets both counters of that thread to zero. It wins over retirements of the same thread in the same cycle.
- R12: Several slots of the same thread in one cycle are applied in slot order, slot 0 first. This applies to the counters and to the consistency checks.
- R13: Counters saturate at 2^CNT_W-1 (7 with defaults). An increment attempted at the maximum sets `ovfErr`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| retValid | input | RET_W | Slot valid |
| retTid | input | RET_W*TID_W | Thread ID per slot |
| retStart | input | RET_W | Transaction begin instruction |
| retStop | input | RET_W | Transaction end instruction |
| retInTx | input | RET_W | Instruction retired in transactional state |
| retTxId | input | RET_W*ID_W | Transaction ID per slot |
| retFault | input | RET_W*4 | Fault code per slot, 0 = none |
| retCause | input | RET_W*3 | Fault cause per slot |
| clrValid | input | 1 | Per-thread counter clear command |
| clrTid | input | TID_W | Thread to clear |
| intPending | input | 1 | Interrupt pending |
| intTid | input | TID_W | Thread picked for retirement |
| drainReq | input | 1 | Drain request |
| qryTid | input | TID_W | Thread for the query outputs |
| fltCode | output | RET_W*4 | Fault code after rewrite |
| fltCause | output | RET_W*3 | Fault cause after rewrite |
| fltTxId | output | RET_W*ID_W | Fault transaction ID |
| intTake | output | 1 | Interrupt passed on for handling |
| intSquash | output | 1 | Interrupt cleared toward the issue stage |
| livelockHold | output | 1 | Livelock-avoidance flag |
| drainGrant | output | 1 | Drain accepted |
| drainErr | output | 1 | Sticky drain refusal flag |
| qryInTx | output | 1 | Query thread inside a transaction |
| qryLastId | output | ID_W | Last retired begin ID of the query thread |
| inTxMask | output | NUM_THREADS | Per-thread transaction state |
| checkErr | output | 1 | Sticky consistency error |
| ovfErr | output | 1 | Sticky counter overflow error |

## Verification
Every registered result appears one cycle after the edge that samples its stimulus:
- the fault outputs;
- the interrupt and drain responses;
- the sticky error flags;
- the counter state behind `inTxMask`.

`qryInTx` and `qryLastId` are combinational from that state, so they follow a change of `qryTid` at once. The bench drives inputs on the falling edge and samples on the next falling edge, which is half a period after the one rising edge that registers them. It then returns the inputs to idle, so no stimulus spans two edges. The query checks first move `qryTid` and then wait a short delay before sampling.

// File: rtl/txn_pkg.sv
package txn_pkg;
  localparam int FLT_W   = 4;
  localparam int CAUSE_W = 3;
  localparam logic [FLT_W-1:0]   FLT_NONE        = 4'h0;
  localparam logic [FLT_W-1:0]   FLT_TXFAIL      = 4'hE;
  localparam logic [CAUSE_W-1:0] CAUSE_EXCEPTION = 3'd1;

  // per-thread write strobes from control to datapath
  typedef struct packed {
    logic cntLoad;
    logic idLoad;
  } txUpd_t;
endpackage

// File: rtl/txn_ctrl.sv
module txn_ctrl
  import txn_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int RET_W       = 2,
  parameter int CNT_W       = 3,
  parameter int ID_W        = 8,
  parameter int TID_W       = 3
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic [RET_W-1:0]                      retValid,
  input  logic [RET_W-1:0][TID_W-1:0]           retTid,
  input  logic [RET_W-1:0]                      retStart,
  input  logic [RET_W-1:0]                      retStop,
  input  logic [RET_W-1:0]                      retInTx,
  input  logic [RET_W-1:0][ID_W-1:0]            retTxId,
  input  logic                                  clrValid,
  input  logic [TID_W-1:0]                      clrTid,
  input  logic                                  intPending,
  input  logic [TID_W-1:0]                      intTid,
  input  logic                                  drainReq,
  input  logic [NUM_THREADS-1:0][CNT_W-1:0]     startCnt,
  input  logic [NUM_THREADS-1:0][CNT_W-1:0]     stopCnt,
  output txUpd_t [NUM_THREADS-1:0]              upd,
  output logic [NUM_THREADS-1:0][CNT_W-1:0]     startNext,
  output logic [NUM_THREADS-1:0][CNT_W-1:0]     stopNext,
  output logic [NUM_THREADS-1:0][ID_W-1:0]      idNext,
  output logic [NUM_THREADS-1:0]                inTxMask,
  output logic                                  intTake,
  output logic                                  intSquash,
  output logic                                  livelockHold,
  output logic                                  drainGrant,
  output logic                                  drainErr,
  output logic                                  checkErr,
  output logic                                  ovfErr
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic mismatch;
  logic satHit;
  logic selInTx;
  logic anyInTx;

  // transaction state per thread from committed counts
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_state
    assign inTxMask[t] = startCnt[t] > stopCnt[t];
  end

  assign anyInTx = |inTxMask;

  always_comb begin
    selInTx = 1'b0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (intTid == TID_W'(t) && inTxMask[t]) selInTx = 1'b1;
    end
  end

  // walk retirement slots in program order for every thread
  always_comb begin : walk
    logic [CNT_W-1:0] s;
    logic [CNT_W-1:0] p;
    mismatch = 1'b0;
    satHit   = 1'b0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      s = startCnt[t];
      p = stopCnt[t];
      upd[t] = '0;
      idNext[t] = '0;
      for (int k = 0; k < RET_W; k++) begin
        if (retValid[k] && retTid[k] == TID_W'(t)) begin
          upd[t].cntLoad = 1'b1;
          if (retStart[k]) begin
            if (s == CNT_MAX) satHit = 1'b1;
            else              s = s + 1'b1;
            upd[t].idLoad = 1'b1;
            idNext[t]     = retTxId[k];
          end
          if ((s > p) != retInTx[k]) mismatch = 1'b1;
          if (retStop[k]) begin
            if (p == CNT_MAX) satHit = 1'b1;
            else              p = p + 1'b1;
          end
        end
      end
      if (clrValid && clrTid == TID_W'(t)) begin
        s = '0;
        p = '0;
        upd[t].cntLoad = 1'b1;
      end
      startNext[t] = s;
      stopNext[t]  = p;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intTake      <= 1'b0;
      intSquash    <= 1'b0;
      livelockHold <= 1'b0;
      drainGrant   <= 1'b0;
      drainErr     <= 1'b0;
      checkErr     <= 1'b0;
      ovfErr       <= 1'b0;
    end else begin
      intTake    <= intPending && !selInTx;
      intSquash  <= intPending && selInTx;
      if (intPending) livelockHold <= selInTx;
      drainGrant <= drainReq && !anyInTx;
      if (drainReq && anyInTx) drainErr <= 1'b1;
      if (mismatch) checkErr <= 1'b1;
      if (satHit)   ovfErr   <= 1'b1;
    end
  end

  p_int_resp_r6: assert property (@(posedge clk) disable iff (!rstN)
    intPending |=> (intTake || intSquash));
  p_squash_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    intSquash |-> livelockHold);
  p_take_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    intTake |-> !livelockHold);
  p_drain_refuse_r10: assert property (@(posedge clk) disable iff (!rstN)
    (drainReq && anyInTx) |=> (drainErr && !drainGrant));
  p_check_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    checkErr |=> checkErr);
  p_ovf_sticky_r13: assert property (@(posedge clk) disable iff (!rstN)
    ovfErr |=> ovfErr);

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_chk
    p_clear_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
      (clrValid && clrTid == TID_W'(t)) |=> (startCnt[t] == '0 && stopCnt[t] == '0));
    p_saturate_r13: assert property (@(posedge clk) disable iff (!rstN)
      (startCnt[t] == CNT_MAX && !(clrValid && clrTid == TID_W'(t)))
        |=> startCnt[t] == CNT_MAX);
  end
endmodule

// File: rtl/txn_datapath.sv
module txn_datapath
  import txn_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int RET_W       = 2,
  parameter int CNT_W       = 3,
  parameter int ID_W        = 8
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  txUpd_t [NUM_THREADS-1:0]              upd,
  input  logic [NUM_THREADS-1:0][CNT_W-1:0]     startNext,
  input  logic [NUM_THREADS-1:0][CNT_W-1:0]     stopNext,
  input  logic [NUM_THREADS-1:0][ID_W-1:0]      idNext,
  input  logic [RET_W-1:0]                      retValid,
  input  logic [RET_W-1:0]                      retInTx,
  input  logic [RET_W-1:0][ID_W-1:0]            retTxId,
  input  logic [RET_W-1:0][FLT_W-1:0]           retFault,
  input  logic [RET_W-1:0][CAUSE_W-1:0]         retCause,
  output logic [NUM_THREADS-1:0][CNT_W-1:0]     startCnt,
  output logic [NUM_THREADS-1:0][CNT_W-1:0]     stopCnt,
  output logic [NUM_THREADS-1:0][ID_W-1:0]      lastId,
  output logic [RET_W-1:0][FLT_W-1:0]           fltCode,
  output logic [RET_W-1:0][CAUSE_W-1:0]         fltCause,
  output logic [RET_W-1:0][ID_W-1:0]            fltTxId
);
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    always_ff @(posedge clk) begin
      if (!rstN) begin
        startCnt[t] <= '0;
        stopCnt[t]  <= '0;
        lastId[t]   <= '0;
      end else begin
        if (upd[t].cntLoad) begin
          startCnt[t] <= startNext[t];
          stopCnt[t]  <= stopNext[t];
        end
        if (upd[t].idLoad) lastId[t] <= idNext[t];
      end
    end
  end

  for (genvar k = 0; k < RET_W; k++) begin : g_slot
    logic rewrite;
    assign rewrite = retValid[k] && retInTx[k] &&
                     retFault[k] != FLT_NONE && retFault[k] != FLT_TXFAIL;

    always_ff @(posedge clk) begin
      if (!rstN || !retValid[k]) begin
        fltCode[k]  <= FLT_NONE;
        fltCause[k] <= '0;
        fltTxId[k]  <= '0;
      end else if (rewrite) begin
        fltCode[k]  <= FLT_TXFAIL;
        fltCause[k] <= CAUSE_EXCEPTION;
        fltTxId[k]  <= retTxId[k];
      end else begin
        fltCode[k]  <= retFault[k];
        fltCause[k] <= retCause[k];
        fltTxId[k]  <= retTxId[k];
      end
    end

    p_fault_rewrite_r7: assert property (@(posedge clk) disable iff (!rstN)
      (retValid[k] && retInTx[k] && retFault[k] != FLT_NONE && retFault[k] != FLT_TXFAIL)
        |=> (fltCode[k] == FLT_TXFAIL && fltCause[k] == CAUSE_EXCEPTION));
    p_fault_pass_r8: assert property (@(posedge clk) disable iff (!rstN)
      (retValid[k] && !retInTx[k])
        |=> (fltCode[k] == $past(retFault[k]) && fltCause[k] == $past(retCause[k])));
  end
endmodule

// File: rtl/txn_commit_tracker.sv
module txn_commit_tracker
  import txn_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int RET_W       = 2,
  parameter int CNT_W       = 3,
  parameter int ID_W        = 8,
  parameter int TID_W       = $clog2(NUM_THREADS + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [RET_W-1:0]           retValid,
  input  logic [RET_W*TID_W-1:0]     retTid,
  input  logic [RET_W-1:0]           retStart,
  input  logic [RET_W-1:0]           retStop,
  input  logic [RET_W-1:0]           retInTx,
  input  logic [RET_W*ID_W-1:0]      retTxId,
  input  logic [RET_W*4-1:0]         retFault,
  input  logic [RET_W*3-1:0]         retCause,
  input  logic                       clrValid,
  input  logic [TID_W-1:0]           clrTid,
  input  logic                       intPending,
  input  logic [TID_W-1:0]           intTid,
  input  logic                       drainReq,
  input  logic [TID_W-1:0]           qryTid,
  output logic [RET_W*4-1:0]         fltCode,
  output logic [RET_W*3-1:0]         fltCause,
  output logic [RET_W*ID_W-1:0]      fltTxId,
  output logic                       intTake,
  output logic                       intSquash,
  output logic                       livelockHold,
  output logic                       drainGrant,
  output logic                       drainErr,
  output logic                       qryInTx,
  output logic [ID_W-1:0]            qryLastId,
  output logic [NUM_THREADS-1:0]     inTxMask,
  output logic                       checkErr,
  output logic                       ovfErr
);
  logic [RET_W-1:0][TID_W-1:0]          tidA;
  logic [RET_W-1:0][ID_W-1:0]           txIdA;
  logic [RET_W-1:0][FLT_W-1:0]          faultA;
  logic [RET_W-1:0][CAUSE_W-1:0]        causeA;
  logic [RET_W-1:0][FLT_W-1:0]          fltCodeA;
  logic [RET_W-1:0][CAUSE_W-1:0]        fltCauseA;
  logic [RET_W-1:0][ID_W-1:0]           fltTxIdA;
  logic [NUM_THREADS-1:0][CNT_W-1:0]    startCnt;
  logic [NUM_THREADS-1:0][CNT_W-1:0]    stopCnt;
  logic [NUM_THREADS-1:0][CNT_W-1:0]    startNext;
  logic [NUM_THREADS-1:0][CNT_W-1:0]    stopNext;
  logic [NUM_THREADS-1:0][ID_W-1:0]     idNext;
  logic [NUM_THREADS-1:0][ID_W-1:0]     lastId;
  txUpd_t [NUM_THREADS-1:0]             upd;

  for (genvar k = 0; k < RET_W; k++) begin : g_unpack
    assign tidA[k]   = retTid[k*TID_W +: TID_W];
    assign txIdA[k]  = retTxId[k*ID_W +: ID_W];
    assign faultA[k] = retFault[k*FLT_W +: FLT_W];
    assign causeA[k] = retCause[k*CAUSE_W +: CAUSE_W];
    assign fltCode[k*FLT_W +: FLT_W]       = fltCodeA[k];
    assign fltCause[k*CAUSE_W +: CAUSE_W]  = fltCauseA[k];
    assign fltTxId[k*ID_W +: ID_W]         = fltTxIdA[k];
  end

  txn_ctrl #(
    .NUM_THREADS(NUM_THREADS), .RET_W(RET_W), .CNT_W(CNT_W),
    .ID_W(ID_W), .TID_W(TID_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN),
    .retValid(retValid), .retTid(tidA), .retStart(retStart), .retStop(retStop),
    .retInTx(retInTx), .retTxId(txIdA),
    .clrValid(clrValid), .clrTid(clrTid),
    .intPending(intPending), .intTid(intTid), .drainReq(drainReq),
    .startCnt(startCnt), .stopCnt(stopCnt),
    .upd(upd), .startNext(startNext), .stopNext(stopNext), .idNext(idNext),
    .inTxMask(inTxMask), .intTake(intTake), .intSquash(intSquash),
    .livelockHold(livelockHold), .drainGrant(drainGrant), .drainErr(drainErr),
    .checkErr(checkErr), .ovfErr(ovfErr)
  );

  txn_datapath #(
    .NUM_THREADS(NUM_THREADS), .RET_W(RET_W), .CNT_W(CNT_W), .ID_W(ID_W)
  ) dp_i (
    .clk(clk), .rstN(rstN),
    .upd(upd), .startNext(startNext), .stopNext(stopNext), .idNext(idNext),
    .retValid(retValid), .retInTx(retInTx), .retTxId(txIdA),
    .retFault(faultA), .retCause(causeA),
    .startCnt(startCnt), .stopCnt(stopCnt), .lastId(lastId),
    .fltCode(fltCodeA), .fltCause(fltCauseA), .fltTxId(fltTxIdA)
  );

  // query port: an ID outside the thread range reads as idle
  always_comb begin
    qryInTx   = 1'b0;
    qryLastId = '0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (qryTid == TID_W'(t)) begin
        qryInTx   = inTxMask[t];
        qryLastId = lastId[t];
      end
    end
  end

  p_invalid_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    (qryTid == {TID_W{1'b1}}) |-> !qryInTx);
endmodule

// File: tb/txn_commit_tracker_tb_top.sv
module txn_commit_tracker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W   = 2;
  localparam int TW  = 3;
  localparam int IW  = 8;

  logic clk = 1'b0;
  logic rstN;
  logic [W-1:0]    retValid, retStart, retStop, retInTx;
  logic [W*TW-1:0] retTid;
  logic [W*IW-1:0] retTxId;
  logic [W*4-1:0]  retFault;
  logic [W*3-1:0]  retCause;
  logic            clrValid, intPending, drainReq;
  logic [TW-1:0]   clrTid, intTid, qryTid;
  logic [W*4-1:0]  fltCode;
  logic [W*3-1:0]  fltCause;
  logic [W*IW-1:0] fltTxId;
  logic intTake, intSquash, livelockHold, drainGrant, drainErr, qryInTx;
  logic [IW-1:0] qryLastId;
  logic [3:0] inTxMask;
  logic checkErr, ovfErr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txn_commit_tracker dut_i (
    .clk(clk), .rstN(rstN), .retValid(retValid), .retTid(retTid),
    .retStart(retStart), .retStop(retStop), .retInTx(retInTx), .retTxId(retTxId),
    .retFault(retFault), .retCause(retCause), .clrValid(clrValid), .clrTid(clrTid),
    .intPending(intPending), .intTid(intTid), .drainReq(drainReq), .qryTid(qryTid),
    .fltCode(fltCode), .fltCause(fltCause), .fltTxId(fltTxId),
    .intTake(intTake), .intSquash(intSquash), .livelockHold(livelockHold),
    .drainGrant(drainGrant), .drainErr(drainErr), .qryInTx(qryInTx),
    .qryLastId(qryLastId), .inTxMask(inTxMask), .checkErr(checkErr), .ovfErr(ovfErr)
  );

  typedef struct packed {
    logic       slot;
    logic       inTx;
    logic [3:0] code;
    logic [2:0] cause;
    logic [7:0] id;
    logic [3:0] eCode;
    logic [2:0] eCause;
    logic [7:0] eId;
  } fv_t;

  localparam fv_t FVEC [6] = '{
    '{1'b0, 1'b1, 4'h3, 3'd5, 8'h11, 4'hE, 3'd1, 8'h11},
    '{1'b0, 1'b1, 4'hE, 3'd4, 8'h22, 4'hE, 3'd4, 8'h22},
    '{1'b0, 1'b0, 4'h3, 3'd5, 8'h33, 4'h3, 3'd5, 8'h33},
    '{1'b1, 1'b1, 4'h0, 3'd0, 8'h44, 4'h0, 3'd0, 8'h44},
    '{1'b1, 1'b1, 4'h7, 3'd2, 8'h55, 4'hE, 3'd1, 8'h55},
    '{1'b1, 1'b0, 4'hE, 3'd6, 8'h66, 4'hE, 3'd6, 8'h66}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    retValid = '0; retStart = '0; retStop = '0; retInTx = '0;
    retTid = '0; retTxId = '0; retFault = '0; retCause = '0;
    clrValid = 1'b0; clrTid = '0; intPending = 1'b0; intTid = '0; drainReq = 1'b0;
  endtask

  task automatic slot(input int k, input int tid, input bit st, input bit sp,
                      input bit itx, input logic [7:0] id);
    retValid[k] = 1'b1;
    retTid[k*TW +: TW] = TW'(tid);
    retStart[k] = st;
    retStop[k]  = sp;
    retInTx[k]  = itx;
    retTxId[k*IW +: IW] = id;
  endtask

  // one rising edge registers the stimulus; sample at the next falling edge
  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  task automatic query(input int tid);
    qryTid = TW'(tid);
    #1;
  endtask

  task automatic finish();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    idle();
    qryTid = '0;
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 inTxMask", 32'(inTxMask), 0);
    chk("R1 checkErr", 32'(checkErr), 0);
    chk("R1 ovfErr", 32'(ovfErr), 0);
    chk("R1 drainErr", 32'(drainErr), 0);
    chk("R1 livelockHold", 32'(livelockHold), 0);
    chk("R1 intTake", 32'(intTake), 0);
    query(1);
    chk("R1 qryLastId", 32'(qryLastId), 0);
    // R2 invalid ID query
    query(7);
    chk("R2 invalid query", 32'(qryInTx), 0);

    // R7 / R8 fault vectors, on the invalid thread so counters stay untouched
    for (int i = 0; i < 6; i++) begin
      int k;
      k = int'(FVEC[i].slot);
      slot(k, 7, 1'b0, 1'b0, FVEC[i].inTx, FVEC[i].id);
      retFault[k*4 +: 4] = FVEC[i].code;
      retCause[k*3 +: 3] = FVEC[i].cause;
      tick();
      chk("R7/R8 code", 32'(fltCode[k*4 +: 4]), 32'(FVEC[i].eCode));
      chk("R7/R8 cause", 32'(fltCause[k*3 +: 3]), 32'(FVEC[i].eCause));
      chk("R7/R8 txid", 32'(fltTxId[k*IW +: IW]), 32'(FVEC[i].eId));
    end
    chk("R2 invalid slot no check", 32'(checkErr), 0);

    // R3 / R9 thread 1 begins
    slot(0, 1, 1'b1, 1'b0, 1'b1, 8'hA5);
    tick();
    query(1);
    chk("R3 begin in tx", 32'(qryInTx), 1);
    chk("R9 lastId", 32'(qryLastId), 32'hA5);
    chk("R3 no mismatch", 32'(checkErr), 0);
    chk("R2 mask", 32'(inTxMask), 32'h2);

    // R5 interrupt inside transaction
    intPending = 1'b1; intTid = 3'd1;
    tick();
    chk("R5 squash", 32'(intSquash), 1);
    chk("R5 no take", 32'(intTake), 0);
    chk("R5 livelock", 32'(livelockHold), 1);

    // R10 drain refused
    drainReq = 1'b1;
    tick();
    chk("R10 drainErr", 32'(drainErr), 1);
    chk("R10 no grant", 32'(drainGrant), 0);

    // R3 end instruction still flagged in-transaction
    slot(0, 1, 1'b0, 1'b1, 1'b1, 8'h00);
    tick();
    chk("R3 end no mismatch", 32'(checkErr), 0);
    query(1);
    chk("R3 end leaves tx", 32'(qryInTx), 0);

    // R6 interrupt outside transaction
    intPending = 1'b1; intTid = 3'd1;
    tick();
    chk("R6 take", 32'(intTake), 1);
    chk("R6 no squash", 32'(intSquash), 0);
    chk("R6 livelock released", 32'(livelockHold), 0);
    intPending = 1'b1; intTid = 3'd7;
    tick();
    chk("R2 invalid int tid taken", 32'(intTake), 1);

    drainReq = 1'b1;
    tick();
    chk("R10 grant", 32'(drainGrant), 1);

    // R9 / R12 nested begins on thread 2 in one cycle
    slot(0, 2, 1'b1, 1'b0, 1'b1, 8'h10);
    slot(1, 2, 1'b1, 1'b0, 1'b1, 8'h20);
    tick();
    query(2);
    chk("R12 nested in tx", 32'(qryInTx), 1);
    chk("R9 later slot wins", 32'(qryLastId), 32'h20);
    chk("R12 no mismatch", 32'(checkErr), 0);
    slot(0, 2, 1'b0, 1'b1, 1'b1, 8'h00);
    slot(1, 2, 1'b0, 1'b1, 1'b1, 8'h00);
    tick();
    chk("R12 two ends ordered", 32'(checkErr), 0);
    query(2);
    chk("R12 out of tx", 32'(qryInTx), 0);
    slot(0, 2, 1'b1, 1'b0, 1'b1, 8'h30);
    slot(1, 2, 1'b0, 1'b1, 1'b1, 8'h00);
    tick();
    chk("R12 begin then end order", 32'(checkErr), 0);
    query(2);
    chk("R12 closed", 32'(qryInTx), 0);

    // R11 clear wins over same-cycle begin
    slot(0, 0, 1'b1, 1'b0, 1'b1, 8'h01);
    tick();
    query(0);
    chk("R11 pre-clear", 32'(qryInTx), 1);
    slot(0, 0, 1'b1, 1'b0, 1'b1, 8'h02);
    clrValid = 1'b1; clrTid = 3'd0;
    tick();
    query(0);
    chk("R11 cleared", 32'(qryInTx), 0);

    // R13 saturation on thread 0
    for (int c = 0; c < 3; c++) begin
      slot(0, 0, 1'b1, 1'b0, 1'b1, 8'h40);
      slot(1, 0, 1'b1, 1'b0, 1'b1, 8'h41);
      tick();
    end
    slot(0, 0, 1'b1, 1'b0, 1'b1, 8'h42);
    tick();
    chk("R13 no ovf at max", 32'(ovfErr), 0);
    slot(0, 0, 1'b1, 1'b0, 1'b1, 8'h43);
    tick();
    chk("R13 ovf set", 32'(ovfErr), 1);
    query(0);
    chk("R13 still in tx", 32'(qryInTx), 1);
    clrValid = 1'b1; clrTid = 3'd0;
    tick();
    chk("R13 ovf sticky", 32'(ovfErr), 1);
    query(0);
    chk("R11 clear after sat", 32'(qryInTx), 0);

    // R4 mismatch on thread 3
    slot(0, 3, 1'b0, 1'b0, 1'b1, 8'h00);
    tick();
    chk("R4 mismatch", 32'(checkErr), 1);
    tick();
    chk("R4 sticky", 32'(checkErr), 1);

    finish();
  end
endmodule